// File: doc/BRIEF.md
# Serial Control Front End for an Eight-Channel Low-Side Driver

This block is the digital front end of an eight-channel low-side switch. A host talks to it through a four-wire serial slave port. The port has an active-low select, a serial clock, a data input and a data output that can be tri-stated. During one select window the host shifts in a new control byte. At the same time it shifts out a status byte. The status byte reports, for each channel, whether the output pin is above or below the comparator threshold. The control byte is committed to a latch when the window closes, and the latch drives the eight active-low channel controls.

All four port pins are oversampled by a fast system clock. Each pin passes through a two-flop synchroniser, and edge detection runs on the synchronised levels. Status is captured in parallel when the select falls, so the first status bit is already on the data output before the first clock edge. Data moves out on rising serial-clock edges and in on falling ones, most significant bit first in both directions. A frame may carry any number of bits, and only the last eight are kept. This lets several such devices share one select line in a daisy chain. An asynchronous active-low reset switches every channel off.

Top module: `lsd_serial_ctrl`

## Requirements
- R1: `sdo_oe` is 1 only while the synchronised select is low. It rises within three system clocks after `cs_n` falls and drops within three system clocks after `cs_n` rises.
- R2: When the select falls, the shift register loads `pin_level` in parallel. In `pin_level`, bit i = 1 means channel i's pin is above the threshold.
- R3: Right after the select falls, and before any rising edge of `sck`, `sdo` already shows `pin_level[7]`.
- R4: `sdo` changes only on a rising `sck` edge inside a frame. On that edge it takes the current bit 7 of the shift register. On a falling `sck` edge, `sdi` shifts into bit 0 and the contents move toward bit 7. Bit 7 travels first in both directions.
- R5: When the select rises, the shift register is copied to the latch, and `drv_n` equals the latch. `drv_n[i]` = 0 switches channel i on and 1 switches it off.
- R6: `drv_n` holds its value through an entire frame, including while bits are being shifted. It changes only when the select rises or on reset.
- R7: A frame may carry more than eight bits. The latch then receives the last eight bits shifted in. After the eight status bits, `sdo` repeats the `sdi` stream delayed by eight bit times.
- R8: While `rst_n` is low, `drv_n` is 8'hFF (all channels off), `sdo_oe` is 0 and `sdo` is 0, whatever the clock is doing.
- R9: `sck` edges while the select is high are ignored. Neither `sdo` nor `drv_n` changes, and the next frame behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; its fall starts a frame and its rise commits it |
| sck | input | 1 | Serial clock; low whenever `cs_n` changes |
| sdi | input | 1 | Serial data in, sampled on falling `sck` |
| pin_level | input | 8 | Comparator status per channel, 1 = pin above threshold |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| drv_n | output | 8 | Active-low channel controls from the latch |

## Verification
The bench checks that bit 7 of the status is on `sdo` before the first rising clock. A design that waits for that edge would drop the first status bit or shift the whole status stream by one position. Frames of fewer than eight, exactly eight and more than eight bits check the daisy-chain rule. In a short frame, leftover status bits must reach the latch. In a long frame, only the final eight bits may reach the latch, and the data output must echo the input eight bits late. A design that uses a fixed bit counter, or commits on the eighth bit, fails these frames. The bench also reads `drv_n` in the middle of a frame and toggles `sck` while the select is high. A latch that updates early, or a shifter that is not gated by the select, shows up there as a changed output.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Index of each serial pin inside the synchroniser bank.
  localparam int IdxSdi = 0;
  localparam int IdxSck = 1;
  localparam int IdxCs  = 2;
  localparam int NumPins = 3;

  // Level each pin settles to while reset is held (select idles high).
  localparam logic [NumPins-1:0] PinIdle = 3'b100;

  // Edge helpers on a synchronised level and its one-cycle-old copy.
  function automatic logic rose(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/lsd_sync_cell.sv
module lsd_sync_cell #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lsd_shift_core.sv
module lsd_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         present,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] sr_q,
  output logic         so_q
);

  // Move every bit one place toward the MSB and take the new bit at the LSB.
  function automatic logic [W-1:0] shift_toward_msb(input logic [W-1:0] v,
                                                    input logic b);
    return {v[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else if (load) begin
      sr_q <= par_in;
      so_q <= par_in[W-1];
    end else begin
      if (shift)   sr_q <= shift_toward_msb(sr_q, ser_in);
      if (present) so_q <= sr_q[W-1];
    end
  end

endmodule

// File: rtl/lsd_out_latch.sv
module lsd_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] AllOff = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= AllOff;
    else if (commit) q <= d;
  end

endmodule

// File: rtl/lsd_serial_ctrl.sv
module lsd_serial_ctrl #(
  parameter int CH          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic [CH-1:0] pin_level,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [CH-1:0] drv_n
);
  import lsd_pkg::*;

  logic [NumPins-1:0] pin_raw;
  logic [NumPins-1:0] pin_lvl;

  assign pin_raw[IdxSdi] = sdi;
  assign pin_raw[IdxSck] = sck;
  assign pin_raw[IdxCs]  = cs_n;

  generate
    for (genvar g = 0; g < NumPins; g++) begin : g_sync
      lsd_sync_cell #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(PinIdle[g])
      ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pin_raw[g]),
        .q_sync (pin_lvl[g])
      );
    end
  endgenerate

  logic cs_lvl, sck_lvl, si_lvl;
  assign cs_lvl  = pin_lvl[IdxCs];
  assign sck_lvl = pin_lvl[IdxSck];
  assign si_lvl  = pin_lvl[IdxSdi];

  logic cs_prev, sck_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= PinIdle[IdxCs];
      sck_prev <= PinIdle[IdxSck];
    end else begin
      cs_prev  <= cs_lvl;
      sck_prev <= sck_lvl;
    end
  end

  // Named internal events, visible to the bound checker.
  logic frame_active;
  logic ev_frame_start, ev_frame_end, ev_shift, ev_present;

  assign frame_active   = ~cs_lvl;
  assign ev_frame_start = fell(cs_prev, cs_lvl);
  assign ev_frame_end   = rose(cs_prev, cs_lvl);
  assign ev_present     = frame_active & rose(sck_prev, sck_lvl);
  assign ev_shift       = frame_active & fell(sck_prev, sck_lvl);

  logic [CH-1:0] sr_q;
  logic          so_q;

  lsd_shift_core #(.W(CH)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_frame_start),
    .shift  (ev_shift),
    .present(ev_present),
    .par_in (pin_level),
    .ser_in (si_lvl),
    .sr_q   (sr_q),
    .so_q   (so_q)
  );

  lsd_out_latch #(.W(CH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(ev_frame_end),
    .d     (sr_q),
    .q     (drv_n)
  );

  assign sdo    = so_q;
  assign sdo_oe = frame_active;

endmodule

// File: rtl/lsd_serial_ctrl_chk.sv
module lsd_serial_ctrl_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_frame_start,
  input logic          ev_frame_end,
  input logic          ev_shift,
  input logic          ev_present,
  input logic          si_lvl,
  input logic [CH-1:0] sr_q,
  input logic [CH-1:0] pin_level,
  input logic          sdo,
  input logic          sdo_oe,
  input logic [CH-1:0] drv_n
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_start |=> sr_q == $past(pin_level));

  p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_start |=> sdo == $past(pin_level[CH-1]));

  p_oe_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_start |=> sdo_oe);

  p_oe_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |=> !sdo_oe);

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> sr_q == {$past(sr_q[CH-2:0]), $past(si_lvl)});

  p_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_present |=> sdo == $past(sr_q[CH-1]));

  p_sdo_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_present && !ev_frame_start) |=> $stable(sdo));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |=> drv_n == $past(sr_q));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_frame_end |=> $stable(drv_n));

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_shift || ev_present) |-> sdo_oe);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_r8: assert (drv_n == '1 && !sdo_oe && !sdo);
    end
  end

endmodule

bind lsd_serial_ctrl lsd_serial_ctrl_chk #(.CH(CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_frame_start(ev_frame_start),
  .ev_frame_end  (ev_frame_end),
  .ev_shift      (ev_shift),
  .ev_present    (ev_present),
  .si_lvl        (si_lvl),
  .sr_q          (sr_q),
  .pin_level     (pin_level),
  .sdo           (sdo),
  .sdo_oe        (sdo_oe),
  .drv_n         (drv_n)
);

// File: tb/test_lsd_serial_ctrl.sv
module test_lsd_serial_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] pin_level = 8'h00;
  logic       sdo, sdo_oe;
  logic [7:0] drv_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lsd_serial_ctrl i_lsd_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .pin_level(pin_level), .sdo(sdo), .sdo_oe(sdo_oe), .drv_n(drv_n)
  );

  // Scoreboard item: which output to look at, the value it should hold, the requirement.
  typedef struct {
    int         kind;   // 0 sdo, 1 drv_n, 2 sdo_oe
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;

  // Monitor: pops each expectation when the driver signals that outputs have settled.
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = exp_q.pop_front();
        case (e.kind)
          0:       act = {7'b0, sdo};
          1:       act = drv_n;
          default: act = {7'b0, sdo_oe};
        endcase
        checks++;
        if (act !== e.val) begin
          fails++;
          $display("FAIL %s: kind %0d actual %h expected %h", e.req, e.kind, act, e.val);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic sample();
    -> sample_ev;
    #1;
  endtask

  logic [7:0] model_latch = 8'hFF;
  logic       model_sdo   = 1'b0;

  // One frame: status st, then n data bits taken from d, most significant first.
  task automatic frame(input logic [7:0] st, input logic [31:0] d, input int n);
    logic [39:0] tail;
    logic [31:0] mask;
    pin_level = st;
    cs_n = 1'b0;
    settle();
    push(2, 8'h01, "R1 oe on");
    push(0, {7'b0, st[7]}, "R3 first bit");
    sample();
    for (int i = 0; i < n; i++) begin
      logic exp_bit;
      sdi = d[n-1-i];
      sck = 1'b1;
      settle();
      exp_bit = (i < 8) ? st[7-i] : d[n-1-(i-8)];
      model_sdo = exp_bit;
      push(0, {7'b0, exp_bit}, (i < 8) ? "R2 R4 status bit" : "R7 echo bit");
      if (i == n / 2) push(1, model_latch, "R6 hold mid frame");
      sample();
      sck = 1'b0;
      settle();
    end
    cs_n = 1'b1;
    settle();
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    tail = ({32'b0, st} << n) | {8'b0, d & mask};
    model_latch = tail[7:0];
    push(1, model_latch, "R5 R7 commit");
    push(2, 8'h00, "R1 oe off");
    sample();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state, with the clock running
    push(1, 8'hFF, "R8 reset drv_n");
    push(2, 8'h00, "R8 reset oe");
    push(0, 8'h00, "R8 reset sdo");
    sample();
    rst_n = 1'b1;
    settle();

    frame(8'hA5, 32'h0000_003C, 8);   // exact byte
    frame(8'h5A, 32'h0000_0000, 8);   // all channels on
    frame(8'hC3, 32'h0000_0005, 3);   // short frame keeps status bits
    frame(8'h81, 32'h0000_9F6E, 16);  // daisy chain, two bytes
    frame(8'h0F, 32'h0012_34F0, 24);  // longer chain

    // R9: clock toggles with the select high leave outputs alone
    for (int k = 0; k < 5; k++) begin
      sdi = k[0];
      sck = 1'b1; settle();
      sck = 1'b0; settle();
    end
    push(0, {7'b0, model_sdo}, "R9 sdo idle");
    push(1, model_latch, "R9 drv_n idle");
    push(2, 8'h00, "R9 oe idle");
    sample();
    frame(8'h3C, 32'h0000_00FF, 8);   // next frame after idle clocks, all off

    frame(8'hFF, 32'h0000_0011, 8);
    // R8 asynchronous reset mid-operation
    rst_n = 1'b0;
    #3;
    push(1, 8'hFF, "R8 async clear");
    push(0, 8'h00, "R8 async sdo");
    sample();
    settle();
    rst_n = 1'b1;
    settle();
    model_latch = 8'hFF;
    frame(8'h96, 32'h0000_0069, 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule